// File: doc/BRIEF.md
# Mode-Selectable Branch Direction Predictor

This block gives a taken or not-taken guess for a conditional branch. A 3-bit mode input picks the policy at run time. Four policies are static and keep no state: always taken, always not-taken, backward-taken/forward-not-taken, and taken by opcode class. Three policies are dynamic and learn from resolved branches: a table of one-bit last-outcome entries, a table of saturating two-bit counters, and a pattern table of two-bit counters indexed only by a global outcome history register. The fetch stage presents a branch address, its target address and an opcode class, and the guess comes back combinationally in the same cycle.

When a branch resolves, the back end sends its address and its real outcome on the update port. Every dynamic structure trains on every update, whatever the current mode. Because of this, switching modes finds each table already warm. A registered update is visible to a lookup in the next cycle. The reset input is asserted asynchronously and released through a two-stage synchronizer.

Top module: `bp_mode_predictor`

## Requirements
- R1: With mode 0, the prediction is taken for every lookup.
- R2: With mode 1, the prediction is not-taken for every lookup. The unused mode 7 also predicts not-taken.
- R3: With mode 2, the prediction is taken exactly when the target address is strictly below the branch address. An equal address predicts not-taken.
- R4: With mode 3, the prediction is bit `opc` of the parameter `OPC_TAKEN_MASK`, whose default is 8'hA6 (classes 1, 2, 5 and 7 taken).
- R5: With mode 4, the prediction is the one-bit entry selected by address bits [IDX_W-1:0]. An update whose outcome differs from the stored bit inverts it, so each entry holds the last outcome seen for its index.
- R6: With mode 5, the prediction is taken when the two-bit counter selected by address bits [IDX_W-1:0] is 2 or 3. A taken update increments that counter and a not-taken update decrements it.
- R7: The two-bit counters saturate. They stay at 3 on further taken updates and at 0 on further not-taken updates.
- R8: With mode 6, the prediction is taken when the pattern-table counter selected by the current history value is 2 or more.
- R9: On an update, the pattern-table counter selected by the history value before the update is trained. The outcome is then shifted into history bit 0, with 1 meaning taken. Without an update, the history holds.
- R10: After reset, every one-bit entry is not-taken, every two-bit counter is 1, and the history is zero, so modes 4, 5 and 6 all predict not-taken.
- R11: Each update trains the one-bit table, the two-bit table and the global scheme in every mode. The trained state is visible to lookups in the cycle after the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Policy select (0 taken, 1 not-taken, 2 backward, 3 opcode, 4 one-bit, 5 two-bit, 6 global) |
| lk_pc_i | input | PC_W | Address of the branch being looked up |
| lk_tgt_i | input | PC_W | Target address of that branch |
| lk_opc_i | input | OPC_W | Opcode class of that branch |
| pred_taken_o | output | 1 | Prediction, 1 = taken |
| up_valid_i | input | 1 | A resolved branch is presented this cycle |
| up_pc_i | input | PC_W | Address of the resolved branch |
| up_taken_i | input | 1 | Resolved outcome, 1 = taken |

## Verification
The bench aims at the following corner cases, and at the fault each one exposes:
- Equal target and branch addresses. A design using a non-strict compare would predict them taken.
- Repeated same-direction updates to one counter. A counter without saturation would wrap from 3 to 0 or from 0 to 3 and flip its guess.
- History handling. A design that trains the pattern entry chosen by the new history instead of the old one would diverge from the model. So would a design that shifts the outcome in at the wrong end.
- Training while another mode is selected. A design that trains only the active table would show stale predictions once the mode is switched back.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic [2:0] {
    BP_ALWAYS_T  = 3'd0,
    BP_ALWAYS_NT = 3'd1,
    BP_BACKWARD  = 3'd2,
    BP_OPCLASS   = 3'd3,
    BP_ONE_BIT   = 3'd4,
    BP_TWO_BIT   = 3'd5,
    BP_GLOBAL    = 3'd6,
    BP_RESERVED  = 3'd7
  } bp_mode_e;

  localparam logic [1:0] CNT_RESET = 2'd1;
  localparam logic [1:0] CNT_MAX   = 2'd3;
  localparam logic [1:0] CNT_MIN   = 2'd0;
endpackage

// File: rtl/bp_static_pred.sv
module bp_static_pred
  import bp_pkg::*;
#(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned OPC_W = 3,
  parameter logic [(1<<OPC_W)-1:0] OPC_TAKEN_MASK = 8'hA6
) (
  input  logic [2:0]       mode,
  input  logic [PC_W-1:0]  pc,
  input  logic [PC_W-1:0]  tgt,
  input  logic [OPC_W-1:0] opc,
  output logic             taken
);
  logic backward;
  logic class_hit;

  assign backward  = (tgt < pc);
  assign class_hit = OPC_TAKEN_MASK[opc];

  always_comb begin
    taken = 1'b0;
    unique case (bp_mode_e'(mode))
      BP_ALWAYS_T: taken = 1'b1;
      BP_BACKWARD: taken = backward;
      BP_OPCLASS:  taken = class_hit;
      default:     taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/bp_onebit_table.sv
module bp_onebit_table #(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_bit,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] bit_arr;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic q, d, en, miss;
    assign en   = wr_en && (wr_idx == IDX_W'(i));
    assign miss = (q != wr_taken);
    always_comb begin
      d = q;
      if (miss) d = ~q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= 1'b0;
      else if (en) q <= d;
    end
    assign bit_arr[i] = q;
  end

  assign rd_bit = bit_arr[rd_idx];
endmodule

// File: rtl/bp_counter_table.sv
module bp_counter_table
  import bp_pkg::*;
#(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [1:0]       rd_cnt,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [1:0] cnt_arr [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [1:0] q, d;
    logic       en;
    assign en = wr_en && (wr_idx == IDX_W'(i));
    always_comb begin
      d = q;
      if (wr_taken) begin
        if (q != CNT_MAX) d = q + 2'd1;
      end else begin
        if (q != CNT_MIN) d = q - 2'd1;
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= CNT_RESET;
      else if (en) q <= d;
    end
    assign cnt_arr[i] = q;
  end

  assign rd_cnt = cnt_arr[rd_idx];
endmodule

// File: rtl/bp_global_hist.sv
module bp_global_hist #(
  parameter int unsigned HIST_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              outcome,
  output logic [HIST_W-1:0] hist
);
  logic [HIST_W-1:0] hist_q, hist_d;

  if (HIST_W == 1) begin : g_single
    always_comb hist_d = outcome;
  end else begin : g_multi
    always_comb hist_d = {hist_q[HIST_W-2:0], outcome};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hist_q <= '0;
    else if (shift_en) hist_q <= hist_d;
  end

  assign hist = hist_q;
endmodule

// File: rtl/bp_mode_predictor.sv
module bp_mode_predictor
  import bp_pkg::*;
#(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned OPC_W  = 3,
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned HIST_W = 6,
  parameter logic [(1<<OPC_W)-1:0] OPC_TAKEN_MASK = 8'hA6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode_i,
  input  logic [PC_W-1:0]  lk_pc_i,
  input  logic [PC_W-1:0]  lk_tgt_i,
  input  logic [OPC_W-1:0] lk_opc_i,
  output logic             pred_taken_o,
  input  logic             up_valid_i,
  input  logic [PC_W-1:0]  up_pc_i,
  input  logic             up_taken_i
);
  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic              static_taken;
  logic              one_bit;
  logic [1:0]        two_cnt;
  logic [1:0]        glob_cnt;
  logic [HIST_W-1:0] ghist;
  logic [IDX_W-1:0]  lk_idx, up_idx;
  logic              pred_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign lk_idx = lk_pc_i[IDX_W-1:0];
  assign up_idx = up_pc_i[IDX_W-1:0];

  bp_static_pred #(
    .PC_W(PC_W), .OPC_W(OPC_W), .OPC_TAKEN_MASK(OPC_TAKEN_MASK)
  ) u_static (
    .mode(mode_i), .pc(lk_pc_i), .tgt(lk_tgt_i), .opc(lk_opc_i),
    .taken(static_taken)
  );

  bp_onebit_table #(.IDX_W(IDX_W)) u_onebit (
    .clk(clk), .rst_n(rst_sync_n),
    .rd_idx(lk_idx), .rd_bit(one_bit),
    .wr_en(up_valid_i), .wr_idx(up_idx), .wr_taken(up_taken_i)
  );

  bp_counter_table #(.IDX_W(IDX_W)) u_local_cnt (
    .clk(clk), .rst_n(rst_sync_n),
    .rd_idx(lk_idx), .rd_cnt(two_cnt),
    .wr_en(up_valid_i), .wr_idx(up_idx), .wr_taken(up_taken_i)
  );

  bp_global_hist #(.HIST_W(HIST_W)) u_hist (
    .clk(clk), .rst_n(rst_sync_n),
    .shift_en(up_valid_i), .outcome(up_taken_i), .hist(ghist)
  );

  bp_counter_table #(.IDX_W(HIST_W)) u_pattern (
    .clk(clk), .rst_n(rst_sync_n),
    .rd_idx(ghist), .rd_cnt(glob_cnt),
    .wr_en(up_valid_i), .wr_idx(ghist), .wr_taken(up_taken_i)
  );

  always_comb begin
    pred_d = 1'b0;
    unique case (bp_mode_e'(mode_i))
      BP_ALWAYS_T, BP_ALWAYS_NT,
      BP_BACKWARD, BP_OPCLASS: pred_d = static_taken;
      BP_ONE_BIT:              pred_d = one_bit;
      BP_TWO_BIT:              pred_d = two_cnt[1];
      BP_GLOBAL:               pred_d = glob_cnt[1];
      default:                 pred_d = 1'b0;
    endcase
  end

  assign pred_taken_o = pred_d;
endmodule

// File: rtl/bp_mode_predictor_chk.sv
module bp_mode_predictor_chk #(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned HIST_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        mode,
  input logic [PC_W-1:0]   pc,
  input logic [PC_W-1:0]   tgt,
  input logic              pred,
  input logic              up_valid,
  input logic              up_taken,
  input logic [HIST_W-1:0] hist
);
  // R1
  always_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0) |-> pred);

  // R2
  never_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1 || mode == 3'd7) |-> !pred);

  // R3
  backward_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2) |-> (pred == (tgt < pc)));

  // R9
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> (hist[0] == $past(up_taken)));

  // R9
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(hist));
endmodule

bind bp_mode_predictor bp_mode_predictor_chk #(.PC_W(PC_W), .HIST_W(HIST_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .mode(mode_i), .pc(lk_pc_i), .tgt(lk_tgt_i),
  .pred(pred_taken_o), .up_valid(up_valid_i), .up_taken(up_taken_i), .hist(ghist)
);

// File: tb/bp_mode_predictor_bench.sv
module bp_mode_predictor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 32, OPC_W = 3, IDX_W = 6, HIST_W = 6;
  localparam int DEPTH = 1 << IDX_W;
  localparam int GDEPTH = 1 << HIST_W;
  localparam logic [7:0] MASK = 8'hA6;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [2:0]       mode;
  logic [PC_W-1:0]  lk_pc, lk_tgt, up_pc;
  logic [OPC_W-1:0] lk_opc;
  logic             pred, up_valid, up_taken;

  int checks = 0;
  int fails = 0;

  logic              m_one [DEPTH];
  logic [1:0]        m_two [DEPTH];
  logic [1:0]        m_pat [GDEPTH];
  logic [HIST_W-1:0] m_hist;

  always #(CLK_PERIOD/2) clk = ~clk;

  bp_mode_predictor u_bp_mode_predictor (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .lk_pc_i(lk_pc), .lk_tgt_i(lk_tgt),
    .lk_opc_i(lk_opc), .pred_taken_o(pred), .up_valid_i(up_valid),
    .up_pc_i(up_pc), .up_taken_i(up_taken)
  );

  function automatic logic model_pred(logic [2:0] md, logic [PC_W-1:0] p,
                                      logic [PC_W-1:0] t, logic [OPC_W-1:0] o);
    case (md)
      3'd0: return 1'b1;
      3'd2: return t < p;
      3'd3: return MASK[o];
      3'd4: return m_one[p[IDX_W-1:0]];
      3'd5: return m_two[p[IDX_W-1:0]][1];
      3'd6: return m_pat[m_hist][1];
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_of(logic [2:0] md);
    case (md)
      3'd0: return "R1";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5/R11";
      3'd5: return "R6/R7/R11";
      3'd6: return "R8/R9/R11";
      default: return "R2";
    endcase
  endfunction

  function automatic logic [1:0] sat(logic [1:0] c, logic tk);
    if (tk) return (c == 2'd3) ? c : c + 2'd1;
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: pred=%0b expected=%0b (mode=%0d pc=%h tgt=%h opc=%0d)",
               req, act, exp, mode, lk_pc, lk_tgt, lk_opc);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) begin m_one[i] = 1'b0; m_two[i] = 2'd1; end
    for (int i = 0; i < GDEPTH; i++) m_pat[i] = 2'd1;
    m_hist = '0;
  endtask

  // one cycle: drive lookup and optional update, check, then commit the model
  task automatic step(logic [2:0] md, logic [PC_W-1:0] p, logic [PC_W-1:0] t,
                      logic [OPC_W-1:0] o, logic uv, logic [PC_W-1:0] upc,
                      logic utk, string req);
    @(negedge clk);
    mode = md; lk_pc = p; lk_tgt = t; lk_opc = o;
    up_valid = uv; up_pc = upc; up_taken = utk;
    #1;
    check(req, pred, model_pred(md, p, t, o));
    @(posedge clk);
    #1;
    if (uv) begin
      m_one[upc[IDX_W-1:0]] = utk;
      m_two[upc[IDX_W-1:0]] = sat(m_two[upc[IDX_W-1:0]], utk);
      m_pat[m_hist] = sat(m_pat[m_hist], utk);
      m_hist = {m_hist[HIST_W-2:0], utk};
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : stim
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    rst_n = 1'b0; mode = 3'd0; lk_pc = '0; lk_tgt = '0; lk_opc = '0;
    up_valid = 1'b0; up_pc = '0; up_taken = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10: reset state seen through the dynamic modes
    for (int m = 4; m <= 6; m++) step(3'(m), 32'h40, 32'h80, 3'd0, 1'b0, '0, 1'b0, "R10");

    // R3: equal addresses predict not-taken, backward predicts taken
    step(3'd2, 32'h1000, 32'h1000, 3'd0, 1'b0, '0, 1'b0, "R3");
    step(3'd2, 32'h1000, 32'h0FFC, 3'd0, 1'b0, '0, 1'b0, "R3");
    // R2: reserved mode 7
    step(3'd7, 32'h1000, 32'h0F00, 3'd5, 1'b0, '0, 1'b0, "R2");
    // R4: each opcode class
    for (int c = 0; c < 8; c++) step(3'd3, 32'h20, 32'h40, 3'(c), 1'b0, '0, 1'b0, "R4");

    // R7: saturate high in mode 1 (trains unseen table, R11), then check
    for (int k = 0; k < 5; k++) step(3'd1, 32'h10, 32'h0, 3'd0, 1'b1, 32'h13, 1'b1, "R2");
    step(3'd5, 32'h13, 32'h0, 3'd0, 1'b1, 32'h13, 1'b0, "R7");
    step(3'd5, 32'h13, 32'h0, 3'd0, 1'b0, '0, 1'b0, "R7");
    step(3'd4, 32'h13, 32'h0, 3'd0, 1'b0, '0, 1'b0, "R5");
    // R7: saturate low
    for (int k = 0; k < 6; k++) step(3'd5, 32'h13, 32'h0, 3'd0, 1'b1, 32'h13, 1'b0, "R7");
    step(3'd5, 32'h13, 32'h0, 3'd0, 1'b1, 32'h13, 1'b1, "R7");
    step(3'd5, 32'h13, 32'h0, 3'd0, 1'b1, 32'h13, 1'b1, "R7");
    step(3'd5, 32'h13, 32'h0, 3'd0, 1'b0, '0, 1'b0, "R6");

    // R9: alternating outcomes exercise old-history training
    for (int k = 0; k < 24; k++) step(3'd6, 32'h0, 32'h0, 3'd0, 1'b1, 32'h8, k[0], "R9");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [2:0]      md;
      logic [PC_W-1:0] p, t, upc;
      logic            uv, utk;
      md  = 3'($urandom_range(0, 7));
      p   = {$urandom} & 32'h0000_03FF;
      t   = {$urandom} & 32'h0000_03FF;
      uv  = ($urandom_range(0, 3) != 0);
      upc = {$urandom} & 32'h0000_00FF;
      utk = (upc[2:0] < 3'd5) ? ($urandom_range(0, 9) != 0) : ($urandom_range(0, 9) == 0);
      step(md, p, t, 3'($urandom_range(0, 7)), uv, upc, utk, req_of(md));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule